// File: doc/BRIEF.md
# Dual Counter-Rotating Ring Interconnect

This block joins a parameterised number of nodes through two rings of shift-register stages. Every node owns one stage on each ring. Each stage holds one slot: a valid flag, a destination node index, a source node index and a `DATA_W`-bit payload (64 bits by default). One ring advances every slot one node upward per clock (node i to node i+1, wrapping). The other advances every slot one node downward (node i to node i-1, wrapping). Both rings move on every clock, so each carries its own traffic in the same cycle as the other.

A node offers a packet by raising its inject valid together with a destination and a payload. The block routes the packet on the ring with the fewer hops to the destination. When both rings need the same number of hops, the upward ring is used. The packet is accepted only when the slot arriving at that node on the chosen ring is free. Traffic already moving on the ring always has priority over a new injection. A slot that arrives at its destination is delivered on that node's receive port for the ring and leaves the ring. The freed slot can take a new injection from the same node in the same cycle.

Top module: `ring_bus_dual`

## Requirements
- R1: During and directly after reset, both rings are empty: every receive valid is low, and every node's inject ready is high for any destination other than itself.
- R2: A delivered packet carries, bit for bit, the payload given at injection, and it reports the injecting node's index as its source.
- R3: On the upward ring, a packet accepted at node s for node d appears on node d's upward receive port exactly (d - s) mod NODES cycles after the accepting clock edge.
- R4: On the downward ring, a packet accepted at node s for node d appears on node d's downward receive port exactly (s - d) mod NODES cycles after the accepting clock edge.
- R5: The ring is chosen per packet by comparing the hop counts of R3 and R4. The downward ring is used only when its count is strictly smaller. On a tie, the upward ring is used.
- R6: A node's inject ready is low whenever the slot arriving at its stage on the chosen ring holds a packet for another node. Such a packet is forwarded unchanged to the next stage on the next clock.
- R7: A slot whose destination equals the node holding it is delivered there and removed from the ring. If no injection takes that slot, the next stage receives an empty slot. If the node injects on that ring in the same cycle, the injection is accepted.
- R8: A request whose destination equals the requesting node, or is not below NODES, is ignored: inject ready stays low and nothing appears on any receive port.
- R9: Both rings transfer in the same cycle, so a node can receive on both of its receive ports in one cycle.
- R10: Packets from one source to one destination are delivered in the order in which they were accepted.
- R11: No packet is lost or duplicated. The occupied slots on a ring change each cycle by exactly the injections accepted minus the deliveries made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every stage moves on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset; empties both rings |
| inj_valid | input | NODES | Per-node inject request |
| inj_dst | input | NODES*ID_W | Per-node destination index, node i in bits [i*ID_W +: ID_W] |
| inj_data | input | NODES*DATA_W | Per-node payload, node i in bits [i*DATA_W +: DATA_W] |
| inj_ready | output | NODES | Per-node acceptance; a packet is taken on an edge where valid and ready are both high |
| rcv_cw_valid | output | NODES | Upward-ring delivery at each node |
| rcv_cw_src | output | NODES*ID_W | Source index of the upward-ring delivery |
| rcv_cw_data | output | NODES*DATA_W | Payload of the upward-ring delivery |
| rcv_ccw_valid | output | NODES | Downward-ring delivery at each node |
| rcv_ccw_src | output | NODES*ID_W | Source index of the downward-ring delivery |
| rcv_ccw_data | output | NODES*DATA_W | Payload of the downward-ring delivery |

## Verification
The forwarding and conservation properties assume the receive ports always take what is delivered, because the block has no back-pressure on delivery. The stimulus never stalls a receiver. The bench treats a request as consumed only on an edge where ready was high, and it redraws every request each cycle. This matches the block's lack of any hold-until-accepted rule. Destinations are drawn from 0 to NODES-1, including the requester's own index, so both ignored requests and legal ones are exercised. Out-of-range indices cannot be expressed at the default power-of-two node count.

// File: rtl/rb_pkg.sv
package rb_pkg;

   typedef enum logic {
      DIR_CW  = 1'b0,
      DIR_CCW = 1'b1
   } ring_dir_e;

   // hops needed from one node to another travelling in the given direction
   function automatic int unsigned hop_count(input int unsigned from_n,
                                             input int unsigned to_n,
                                             input int unsigned n,
                                             input ring_dir_e   dir);
      if (dir == DIR_CW) return (to_n + n - from_n) % n;
      else               return (from_n + n - to_n) % n;
   endfunction

endpackage

// File: rtl/rb_route.sv
module rb_route #(
   parameter int NODES   = 8,
   parameter int ID_W    = 3,
   parameter int NODE_ID = 0
) (
   input  logic [ID_W-1:0]     dst,
   output rb_pkg::ring_dir_e   dir,
   output logic                bad
);
   import rb_pkg::*;

   int unsigned up_h;
   int unsigned dn_h;

   always_comb begin
      bad  = (32'(dst) >= NODES) || (32'(dst) == NODE_ID);
      up_h = hop_count(NODE_ID, 32'(dst), NODES, DIR_CW);
      dn_h = hop_count(NODE_ID, 32'(dst), NODES, DIR_CCW);
      // tie goes to the upward ring
      dir  = (dn_h < up_h) ? DIR_CCW : DIR_CW;
   end

endmodule

// File: rtl/rb_stage.sv
module rb_stage #(
   parameter int ID_W    = 3,
   parameter int DATA_W  = 64,
   parameter int NODE_ID = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic [ID_W-1:0]   in_dst,
   input  logic [ID_W-1:0]   in_src,
   input  logic [DATA_W-1:0] in_dat,
   input  logic              ins_req,
   input  logic [ID_W-1:0]   ins_dst,
   input  logic [DATA_W-1:0] ins_dat,
   output logic              take,
   output logic              ready,
   output logic              ins_fire,
   output logic              out_vld,
   output logic [ID_W-1:0]   out_dst,
   output logic [ID_W-1:0]   out_src,
   output logic [DATA_W-1:0] out_dat
);
   localparam logic [ID_W-1:0] MY_ID = ID_W'(NODE_ID);

   logic pass;

   always_comb begin
      take     = in_vld && (in_dst == MY_ID);
      pass     = in_vld && !take;
      ready    = !pass;
      ins_fire = ins_req && ready;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         out_dst <= '0;
         out_src <= '0;
         out_dat <= '0;
      end else begin
         out_vld <= pass || ins_fire;
         if (pass) begin
            out_dst <= in_dst;
            out_src <= in_src;
            out_dat <= in_dat;
         end else if (ins_fire) begin
            out_dst <= ins_dst;
            out_src <= MY_ID;
            out_dat <= ins_dat;
         end
      end
   end

   // R6
   pass_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pass |=> out_vld && out_dst == $past(in_dst) && out_src == $past(in_src)
               && out_dat == $past(in_dat));

   // R7
   slot_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !ins_fire) |=> !out_vld);

endmodule

// File: rtl/rb_ring.sv
module rb_ring #(
   parameter int                NODES  = 8,
   parameter int                ID_W   = 3,
   parameter int                DATA_W = 64,
   parameter rb_pkg::ring_dir_e DIR    = rb_pkg::DIR_CW
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NODES-1:0]         ins_req,
   input  logic [NODES*ID_W-1:0]    ins_dst,
   input  logic [NODES*DATA_W-1:0]  ins_dat,
   output logic [NODES-1:0]         ready,
   output logic [NODES-1:0]         rx_vld,
   output logic [NODES*ID_W-1:0]    rx_src,
   output logic [NODES*DATA_W-1:0]  rx_dat
);
   import rb_pkg::*;

   logic [NODES-1:0]  st_vld;
   logic [ID_W-1:0]   st_dst [NODES];
   logic [ID_W-1:0]   st_src [NODES];
   logic [DATA_W-1:0] st_dat [NODES];
   logic [NODES-1:0]  fire;

   for (genvar g = 0; g < NODES; g++) begin : g_node
      // stage whose register feeds this node
      localparam int UP = (DIR == DIR_CW) ? (g + NODES - 1) % NODES : (g + 1) % NODES;

      rb_stage #(.ID_W(ID_W), .DATA_W(DATA_W), .NODE_ID(g)) u_stage (
         .clk      (clk),
         .rst_n    (rst_n),
         .in_vld   (st_vld[UP]),
         .in_dst   (st_dst[UP]),
         .in_src   (st_src[UP]),
         .in_dat   (st_dat[UP]),
         .ins_req  (ins_req[g]),
         .ins_dst  (ins_dst[g*ID_W +: ID_W]),
         .ins_dat  (ins_dat[g*DATA_W +: DATA_W]),
         .take     (rx_vld[g]),
         .ready    (ready[g]),
         .ins_fire (fire[g]),
         .out_vld  (st_vld[g]),
         .out_dst  (st_dst[g]),
         .out_src  (st_src[g]),
         .out_dat  (st_dat[g])
      );

      assign rx_src[g*ID_W +: ID_W]     = st_src[UP];
      assign rx_dat[g*DATA_W +: DATA_W] = st_dat[UP];
   end

   int occ_n, ins_n, rem_n;
   always_comb begin
      occ_n = $countones(st_vld);
      ins_n = $countones(fire);
      rem_n = $countones(rx_vld);
   end

   // R11
   conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> occ_n == $past(occ_n) + $past(ins_n) - $past(rem_n));

endmodule

// File: rtl/ring_bus_dual.sv
module ring_bus_dual #(
   parameter int NODES  = 8,
   parameter int DATA_W = 64,
   localparam int ID_W  = ($clog2(NODES) < 1) ? 1 : $clog2(NODES)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NODES-1:0]         inj_valid,
   input  logic [NODES*ID_W-1:0]    inj_dst,
   input  logic [NODES*DATA_W-1:0]  inj_data,
   output logic [NODES-1:0]         inj_ready,
   output logic [NODES-1:0]         rcv_cw_valid,
   output logic [NODES*ID_W-1:0]    rcv_cw_src,
   output logic [NODES*DATA_W-1:0]  rcv_cw_data,
   output logic [NODES-1:0]         rcv_ccw_valid,
   output logic [NODES*ID_W-1:0]    rcv_ccw_src,
   output logic [NODES*DATA_W-1:0]  rcv_ccw_data
);
   import rb_pkg::*;

   localparam int RINGS = 2;

   if (NODES < 2) begin : g_bad_nodes
      $error("ring_bus_dual: NODES must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("ring_bus_dual: DATA_W must be positive");
   end

   ring_dir_e        dir  [NODES];
   logic [NODES-1:0] bad;
   logic [NODES-1:0] req_r [RINGS];
   logic [NODES-1:0] rdy_r [RINGS];
   logic [NODES-1:0] rxv_r [RINGS];
   logic [NODES*ID_W-1:0]   rxs_r [RINGS];
   logic [NODES*DATA_W-1:0] rxd_r [RINGS];

   for (genvar g = 0; g < NODES; g++) begin : g_port
      rb_route #(.NODES(NODES), .ID_W(ID_W), .NODE_ID(g)) u_route (
         .dst (inj_dst[g*ID_W +: ID_W]),
         .dir (dir[g]),
         .bad (bad[g])
      );

      always_comb begin
         req_r[0][g]  = inj_valid[g] && !bad[g] && (dir[g] == DIR_CW);
         req_r[1][g]  = inj_valid[g] && !bad[g] && (dir[g] == DIR_CCW);
         inj_ready[g] = !bad[g] && ((dir[g] == DIR_CW) ? rdy_r[0][g] : rdy_r[1][g]);
      end

      // R8
      self_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (32'(inj_dst[g*ID_W +: ID_W]) == g) |-> !inj_ready[g]);

      // R2
      rx_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rcv_cw_valid[g] || rcv_ccw_valid[g]) |->
            (!rcv_cw_valid[g]  || 32'(rcv_cw_src[g*ID_W +: ID_W])  != g) &&
            (!rcv_ccw_valid[g] || 32'(rcv_ccw_src[g*ID_W +: ID_W]) != g));
   end

   for (genvar r = 0; r < RINGS; r++) begin : g_ring
      rb_ring #(
         .NODES  (NODES),
         .ID_W   (ID_W),
         .DATA_W (DATA_W),
         .DIR    ((r == 0) ? DIR_CW : DIR_CCW)
      ) u_ring (
         .clk     (clk),
         .rst_n   (rst_n),
         .ins_req (req_r[r]),
         .ins_dst (inj_dst),
         .ins_dat (inj_data),
         .ready   (rdy_r[r]),
         .rx_vld  (rxv_r[r]),
         .rx_src  (rxs_r[r]),
         .rx_dat  (rxd_r[r])
      );
   end

   assign rcv_cw_valid  = rxv_r[0];
   assign rcv_cw_src    = rxs_r[0];
   assign rcv_cw_data   = rxd_r[0];
   assign rcv_ccw_valid = rxv_r[1];
   assign rcv_ccw_src   = rxs_r[1];
   assign rcv_ccw_data  = rxd_r[1];

endmodule

// File: tb/sim_ring_bus_dual.sv
module sim_ring_bus_dual;
   localparam int N      = 8;
   localparam int DW     = 64;
   localparam int IW     = 3;
   localparam int CLK_NS = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_NS/2) clk = ~clk;

   logic [N-1:0]    inj_valid, inj_ready, rcv_cw_valid, rcv_ccw_valid;
   logic [N*IW-1:0] inj_dst, rcv_cw_src, rcv_ccw_src;
   logic [N*DW-1:0] inj_data, rcv_cw_data, rcv_ccw_data;

   ring_bus_dual #(.NODES(N), .DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .inj_valid(inj_valid), .inj_dst(inj_dst), .inj_data(inj_data), .inj_ready(inj_ready),
      .rcv_cw_valid(rcv_cw_valid), .rcv_cw_src(rcv_cw_src), .rcv_cw_data(rcv_cw_data),
      .rcv_ccw_valid(rcv_ccw_valid), .rcv_ccw_src(rcv_ccw_src), .rcv_ccw_data(rcv_ccw_data)
   );

   // stimulus
   bit          iv   [N];
   int          idst [N];
   logic [63:0] idat [N];
   always_comb
      for (int i = 0; i < N; i++) begin
         inj_valid[i]            = iv[i];
         inj_dst[i*IW +: IW]     = IW'(idst[i]);
         inj_data[i*DW +: DW]    = idat[i];
      end

   // reference model: slot present at each node on each ring
   bit          mv [2][N];
   int          md [2][N];
   int          ms [2][N];
   logic [63:0] mx [2][N];
   bit          acc  [N];
   int          asel [N];
   int          seq_tx [N][N];
   int          seq_rx [N][N];
   int total = 0, bad = 0, accepted = 0, delivered = 0;

   task automatic chk(input longint act, input longint exp, input string req);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_req();
      for (int i = 0; i < N; i++) begin
         iv[i] = 0; idst[i] = (i + 1) % N; idat[i] = '0;
      end
   endtask

   task automatic set_req(input int s, input int d);
      iv[s] = 1; idst[s] = d;
      idat[s] = {16'(s), 16'(d), 32'(seq_tx[s][d])};
   endtask

   // compare the design against the model in the current cycle
   task automatic settle();
      #1;
      for (int i = 0; i < N; i++) begin
         for (int r = 0; r < 2; r++) begin
            bit          ev = mv[r][i] && md[r][i] == i;
            bit          dv = (r == 0) ? rcv_cw_valid[i] : rcv_ccw_valid[i];
            int          dsrc = (r == 0) ? int'(rcv_cw_src[i*IW +: IW]) : int'(rcv_ccw_src[i*IW +: IW]);
            logic [63:0] ddat = (r == 0) ? rcv_cw_data[i*DW +: DW] : rcv_ccw_data[i*DW +: DW];
            chk(dv, ev, $sformatf("%s rx valid node %0d", (r == 0) ? "R3" : "R4", i));
            if (ev) begin
               chk(dsrc, ms[r][i], $sformatf("R2 src node %0d", i));
               chk(ddat, mx[r][i], $sformatf("R2 data node %0d", i));
            end
            if (dv) begin
               delivered++;
               chk(ddat[31:0], seq_rx[dsrc][i], $sformatf("R10 order %0d to %0d", dsrc, i));
               seq_rx[dsrc][i] = int'(ddat[31:0]) + 1;
            end
         end
         begin
            int d = idst[i];
            int uh = (d + N - i) % N;
            int dh = (i + N - d) % N;
            int rs = (dh < uh) ? 1 : 0;
            bit exp_rdy = (d != i) && !(mv[rs][i] && md[rs][i] != i);
            chk(inj_ready[i], exp_rdy, $sformatf("R5 R6 R8 ready node %0d", i));
            acc[i]  = iv[i] && exp_rdy;
            asel[i] = rs;
         end
      end
   endtask

   task automatic adv();
      bit          nv [2][N];
      int          nd [2][N];
      int          ns [2][N];
      logic [63:0] nx [2][N];
      @(posedge clk);
      for (int r = 0; r < 2; r++)
         for (int i = 0; i < N; i++) begin
            int nxt = (r == 0) ? (i + 1) % N : (i + N - 1) % N;
            if (mv[r][i] && md[r][i] != i) begin
               nv[r][nxt] = 1; nd[r][nxt] = md[r][i]; ns[r][nxt] = ms[r][i]; nx[r][nxt] = mx[r][i];
            end else if (acc[i] && asel[i] == r) begin
               nv[r][nxt] = 1; nd[r][nxt] = idst[i]; ns[r][nxt] = i; nx[r][nxt] = idat[i];
            end else begin
               nv[r][nxt] = 0; nd[r][nxt] = 0; ns[r][nxt] = 0; nx[r][nxt] = '0;
            end
         end
      for (int i = 0; i < N; i++)
         if (acc[i]) begin
            accepted++;
            seq_tx[i][idst[i]]++;
         end
      mv = nv; md = nd; ms = ns; mx = nx;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); clear_req(); settle(); adv();
      end
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      summary();
      $finish;
   end

   initial begin
      clear_req();
      for (int r = 0; r < 2; r++)
         for (int i = 0; i < N; i++) begin
            mv[r][i] = 0; md[r][i] = 0; ms[r][i] = 0; mx[r][i] = '0;
         end
      for (int a = 0; a < N; a++)
         for (int b = 0; b < N; b++) begin seq_tx[a][b] = 0; seq_rx[a][b] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state while reset is still asserted
      #1;
      chk(rcv_cw_valid | rcv_ccw_valid, 0, "R1 rx during reset");
      rst_n = 1'b1;

      // R1: first cycle out of reset
      @(negedge clk); clear_req(); settle();
      chk(inj_ready, {N{1'b1}}, "R1 ready after reset");
      chk(rcv_cw_valid | rcv_ccw_valid, 0, "R1 rx after reset");
      adv();

      // R3 R5: tie 0 -> 4 goes upward, four hops
      @(negedge clk); clear_req(); set_req(0, 4); settle();
      chk(inj_ready[0], 1, "R5 tie accept"); adv();
      idle(3);
      @(negedge clk); clear_req(); settle();
      chk(rcv_cw_valid[4], 1, "R3 upward arrival at 4 hops");
      chk(rcv_ccw_valid[4], 0, "R5 tie not downward");
      adv();

      // R4: 0 -> 6 goes downward, two hops
      @(negedge clk); clear_req(); set_req(0, 6); settle(); adv();
      idle(1);
      @(negedge clk); clear_req(); settle();
      chk(rcv_ccw_valid[6], 1, "R4 downward arrival");
      chk(rcv_ccw_src[6*IW +: IW], 0, "R4 downward source");
      adv();
      idle(N);

      // R6: in-transit packet blocks node 1
      @(negedge clk); clear_req(); set_req(0, 3); settle(); adv();
      @(negedge clk); clear_req(); set_req(1, 2); settle();
      chk(inj_ready[1], 0, "R6 transit priority"); adv();
      idle(N);

      // R7: delivered slot reused by the same node in the same cycle
      @(negedge clk); clear_req(); set_req(0, 1); settle(); adv();
      @(negedge clk); clear_req(); set_req(1, 2); settle();
      chk(rcv_cw_valid[1], 1, "R7 delivery at 1");
      chk(inj_ready[1], 1, "R7 reuse accepted"); adv();
      @(negedge clk); clear_req(); settle();
      chk(rcv_cw_valid[2], 1, "R7 reused slot delivered");
      chk(rcv_cw_src[2*IW +: IW], 1, "R7 reused slot source"); adv();
      idle(N);

      // R8: self-addressed request ignored
      @(negedge clk); clear_req(); set_req(3, 3); settle();
      chk(inj_ready[3], 0, "R8 self ready"); adv();
      begin
         int seen = 0;
         for (int k = 0; k < N; k++) begin
            @(negedge clk); clear_req(); settle();
            seen += $countones(rcv_cw_valid | rcv_ccw_valid);
            adv();
         end
         chk(seen, 0, "R8 nothing delivered");
      end

      // R9: both rings deliver at node 2 in the same cycle
      @(negedge clk); clear_req(); set_req(0, 2); set_req(4, 2); settle(); adv();
      idle(1);
      @(negedge clk); clear_req(); settle();
      chk({rcv_cw_valid[2], rcv_ccw_valid[2]}, 2'b11, "R9 dual delivery"); adv();
      idle(N);

      // random traffic: R2 R10 and model comparison every cycle
      for (int c = 0; c < 4000; c++) begin
         @(negedge clk); clear_req();
         for (int i = 0; i < N; i++)
            if ($urandom_range(0, 1) == 1) set_req(i, int'($urandom_range(0, N - 1)));
         settle(); adv();
      end
      idle(N + 2);

      // R11: everything accepted came out exactly once
      chk(delivered, accepted, "R11 conservation");
      summary();
      $finish;
   end
endmodule